// File: doc/BRIEF.md
# Adaptive-Slope Delta Modulation Encoder

This block turns a stream of 16-bit signed samples into a one-bit delta-modulated stream whose step size adapts to the signal slope. At every encoder enable it compares the present sample with an internal running estimate and emits a single bit. It then updates a short history of emitted bits, grows or shrinks the step size from that history, and moves the estimate up or down by the new step. The estimate saturates at full scale and leaks slightly toward zero.

The encoder enable comes from the system clock. A programmable 6-bit divider feeds a fixed divide-by-16 stage. A 2-bit rate code selects 32, 50 or 64 kHz operation. That code sets the step growth and decay constants so that the adaptation time constant stays roughly the same at every rate. Code 00 is not a valid rate, and it halts the encoder. A 2-bit floor code sets the smallest step the adaptation may reach. The three non-zero floor settings are a factor of four apart.

Top module: `cvsd_enc_core`

## Requirements
- R1: While `rst` is high, and after it is released until the first encoder update, `enc_valid` and `enc_bit` are 0, and `est_out` and `step_out` are 0.
- R2: With a valid rate code and a constant `div_load` value N, consecutive `enc_valid` pulses are exactly 16*(N+1) clock cycles apart.
- R3: With rate code 00 held, no `enc_valid` pulse occurs.
- R4: Each `enc_valid` pulse is high for exactly one cycle and carries one bit. `enc_bit` is 1 when the sample present at the update is greater than or equal to the previous estimate, and 0 otherwise.
- R5: A "run" exists when the new bit and the two previous bits are all equal. The bit history starts as two zeros after reset. On a run the step becomes s + (s >> G) + F, where F is the floor. G is 2 for rate code 01 and 3 for rate codes 10 and 11.
- R6: Without a run the step becomes s - (s >> D). D is 4 for rate code 01 and 5 for rate codes 10 and 11.
- R7: After R5 or R6 the step is clamped between the floor F and STEP_MAX (8192). F is 1 for floor code 00, 8 for code 01, 32 for code 10 and 128 for code 11.
- R8: On each update the estimate e first leaks to e - (e >>> 8), using an arithmetic shift. The new step is then added when the bit is 1 and subtracted when the bit is 0. Between updates `est_out` holds its value.
- R9: The estimate saturates at +32767 and -32768 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_load | input | 6 | Terminal count N of the programmable prescaler |
| rate_code | input | 2 | 01 = 32 kHz, 10 = 50 kHz, 11 = 64 kHz, 00 = halted |
| floor_code | input | 2 | Step floor select (1, 8, 32, 128 LSB) |
| sample_in | input | 16 | Signed input sample |
| enc_valid | output | 1 | One-cycle pulse marking a new output bit |
| enc_bit | output | 1 | Encoded bit |
| est_out | output | 16 | Signed running estimate after the update |
| step_out | output | 16 | Step size used in the latest update |

## Verification
Saturation of the estimate is the hardest state to reach from the ports. It needs a long run of equal bits, so that the step first climbs to its ceiling and then pushes the leaked estimate past full scale. The stimulus holds the sample at the positive extreme, and later at the negative extreme, for dozens of updates, under different rate and floor codes. The constrained random phases then change rate and floor codes only between updates, so that every shift-constant and floor pairing is reached during both growth and decay.

// File: rtl/cvsd_pkg.sv
package cvsd_pkg;

  typedef enum logic [1:0] {
    RATE_OFF = 2'b00,
    RATE_32K = 2'b01,
    RATE_50K = 2'b10,
    RATE_64K = 2'b11
  } rate_e;

  // shift applied for step growth on a run of equal bits
  function automatic int unsigned grow_shift(input logic [1:0] rate);
    return (rate == RATE_32K) ? 2 : 3;
  endfunction

  // shift applied for geometric step decay
  function automatic int unsigned decay_shift(input logic [1:0] rate);
    return (rate == RATE_32K) ? 4 : 5;
  endfunction

  // floor in LSB: code 0 -> 1, otherwise base * 4^(code-1)
  function automatic int unsigned floor_lsb(input logic [1:0] code,
                                            input int unsigned base);
    return (code == 2'd0) ? 1 : (base << (2 * (code - 1)));
  endfunction

endpackage

// File: rtl/cvsd_ce_gen.sv
module cvsd_ce_gen #(
  parameter int PRE_W    = 6,
  parameter int POST_DIV = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PRE_W-1:0] div_load,
  output logic             ce
);
  localparam int POST_W = $clog2(POST_DIV);

  logic [PRE_W-1:0]  pre_cnt;
  logic [POST_W-1:0] post_cnt;
  logic              pre_tick;

  assign pre_tick = run && (pre_cnt >= div_load);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pre_cnt  <= '0;
      post_cnt <= '0;
      ce       <= 1'b0;
    end else begin
      ce <= 1'b0;
      if (pre_tick) begin
        pre_cnt <= '0;
        if (post_cnt == POST_W'(POST_DIV - 1)) begin
          post_cnt <= '0;
          ce       <= 1'b1;
        end else begin
          post_cnt <= post_cnt + 1'b1;
        end
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cvsd_step_adapt.sv
module cvsd_step_adapt
  import cvsd_pkg::*;
#(
  parameter int STEP_W    = 16,
  parameter int STEP_MAX  = 8192,
  parameter int FLOOR_BASE = 8,
  parameter int HIST_LEN  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              new_bit,
  input  logic [1:0]        rate_code,
  input  logic [1:0]        floor_code,
  output logic [STEP_W-1:0] step_nxt,
  output logic [STEP_W-1:0] step_q
);
  localparam int CALC_W = STEP_W + 2;

  logic [HIST_LEN-2:0] hist;
  logic [HIST_LEN-1:0] win;
  logic                run_eq;
  logic [CALC_W-1:0]   s_ext, floor_v, grown, decayed, raw;

  assign win    = {hist, new_bit};
  assign run_eq = (win == '0) || (win == '1);

  always_comb begin
    s_ext   = CALC_W'(step_q);
    floor_v = CALC_W'(floor_lsb(floor_code, FLOOR_BASE));
    grown   = s_ext + (s_ext >> grow_shift(rate_code)) + floor_v;
    decayed = s_ext - (s_ext >> decay_shift(rate_code));
    raw     = run_eq ? grown : decayed;
    if (raw < floor_v)                   step_nxt = STEP_W'(floor_v);
    else if (raw > CALC_W'(STEP_MAX))    step_nxt = STEP_W'(STEP_MAX);
    else                                 step_nxt = STEP_W'(raw);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist   <= '0;
      step_q <= '0;
    end else if (ce) begin
      hist   <= win[HIST_LEN-2:0];
      step_q <= step_nxt;
    end
  end
endmodule

// File: rtl/cvsd_integrator.sv
module cvsd_integrator #(
  parameter int SAMP_W  = 16,
  parameter int STEP_W  = 16,
  parameter int LEAK_SH = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ce,
  input  logic                     dir_up,
  input  logic [STEP_W-1:0]        step,
  output logic signed [SAMP_W-1:0] est_q
);
  localparam int ACC_W = SAMP_W + 2;
  localparam logic signed [ACC_W-1:0] POS_LIM = ACC_W'((1 <<< (SAMP_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] NEG_LIM = -ACC_W'(1 <<< (SAMP_W - 1));

  logic signed [ACC_W-1:0] e_ext, leaked, step_ext, sum;
  logic signed [SAMP_W-1:0] est_nxt;

  always_comb begin
    e_ext    = ACC_W'(est_q);
    leaked   = e_ext - (e_ext >>> LEAK_SH);
    step_ext = $signed({2'b00, step});
    sum      = dir_up ? leaked + step_ext : leaked - step_ext;
    if (sum > POS_LIM)      est_nxt = SAMP_W'(POS_LIM);
    else if (sum < NEG_LIM) est_nxt = SAMP_W'(NEG_LIM);
    else                    est_nxt = SAMP_W'(sum);
  end

  always_ff @(posedge clk) begin
    if (rst)     est_q <= '0;
    else if (ce) est_q <= est_nxt;
  end
endmodule

// File: rtl/cvsd_enc_core.sv
module cvsd_enc_core
  import cvsd_pkg::*;
#(
  parameter int SAMP_W     = 16,
  parameter int STEP_W     = 16,
  parameter int PRE_W      = 6,
  parameter int POST_DIV   = 16,
  parameter int STEP_MAX   = 8192,
  parameter int FLOOR_BASE = 8,
  parameter int LEAK_SH    = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [PRE_W-1:0]         div_load,
  input  logic [1:0]               rate_code,
  input  logic [1:0]               floor_code,
  input  logic signed [SAMP_W-1:0] sample_in,
  output logic                     enc_valid,
  output logic                     enc_bit,
  output logic signed [SAMP_W-1:0] est_out,
  output logic [STEP_W-1:0]        step_out
);
  logic ce;
  logic bit_now;
  logic [STEP_W-1:0] step_nxt;

  cvsd_ce_gen #(.PRE_W(PRE_W), .POST_DIV(POST_DIV)) u_ce (
    .clk(clk), .rst(rst), .run(rate_code != RATE_OFF),
    .div_load(div_load), .ce(ce)
  );

  assign bit_now = (sample_in >= est_out);

  cvsd_step_adapt #(.STEP_W(STEP_W), .STEP_MAX(STEP_MAX),
                    .FLOOR_BASE(FLOOR_BASE), .HIST_LEN(3)) u_step (
    .clk(clk), .rst(rst), .ce(ce), .new_bit(bit_now),
    .rate_code(rate_code), .floor_code(floor_code),
    .step_nxt(step_nxt), .step_q(step_out)
  );

  cvsd_integrator #(.SAMP_W(SAMP_W), .STEP_W(STEP_W), .LEAK_SH(LEAK_SH)) u_int (
    .clk(clk), .rst(rst), .ce(ce), .dir_up(bit_now),
    .step(step_nxt), .est_q(est_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      enc_valid <= 1'b0;
      enc_bit   <= 1'b0;
    end else begin
      enc_valid <= ce;
      if (ce) enc_bit <= bit_now;
    end
  end
endmodule

// File: rtl/cvsd_enc_core_chk.sv
module cvsd_enc_core_chk #(
  parameter int SAMP_W     = 16,
  parameter int STEP_W     = 16,
  parameter int STEP_MAX   = 8192,
  parameter int FLOOR_BASE = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic [1:0]               rate_code,
  input logic [1:0]               floor_code,
  input logic signed [SAMP_W-1:0] sample_in,
  input logic                     enc_valid,
  input logic                     enc_bit,
  input logic signed [SAMP_W-1:0] est_out,
  input logic [STEP_W-1:0]        step_out
);
  // R4
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    enc_valid |=> !enc_valid);

  // R3
  halted_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rate_code) == 2'b00 && $past(rate_code, 2) == 2'b00) |-> !enc_valid);

  // R4
  bit_dir_chk: assert property (@(posedge clk) disable iff (rst)
    enc_valid |-> (enc_bit == ($past(sample_in) >= $past(est_out))));

  // R7
  step_floor_chk: assert property (@(posedge clk) disable iff (rst)
    enc_valid |-> (32'(step_out) >= cvsd_pkg::floor_lsb($past(floor_code), FLOOR_BASE)));

  // R7
  step_ceil_chk: assert property (@(posedge clk) disable iff (rst)
    32'(step_out) <= STEP_MAX);

  // R8
  est_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !enc_valid |-> $stable(est_out));
endmodule

bind cvsd_enc_core cvsd_enc_core_chk #(
  .SAMP_W(SAMP_W), .STEP_W(STEP_W), .STEP_MAX(STEP_MAX), .FLOOR_BASE(FLOOR_BASE)
) u_chk (
  .clk(clk), .rst(rst), .rate_code(rate_code), .floor_code(floor_code),
  .sample_in(sample_in), .enc_valid(enc_valid), .enc_bit(enc_bit),
  .est_out(est_out), .step_out(step_out)
);

// File: tb/cvsd_enc_core_tb.sv
module cvsd_enc_core_tb;
  logic clk = 1'b0;
  logic rst;
  logic [5:0] div_load;
  logic [1:0] rate_code, floor_code;
  logic signed [15:0] sample_in;
  logic enc_valid, enc_bit;
  logic signed [15:0] est_out;
  logic [15:0] step_out;

  int checks = 0, failures = 0;
  int cyc = 0, last_cyc = 0;
  bit period_ok = 0;
  int m_est = 0, m_step = 0;
  bit [1:0] m_hist = 2'b00;
  bit seen_pos = 0, seen_neg = 0;

  always #4 clk = ~clk;

  cvsd_enc_core u_dut (
    .clk(clk), .rst(rst), .div_load(div_load), .rate_code(rate_code),
    .floor_code(floor_code), .sample_in(sample_in), .enc_valid(enc_valid),
    .enc_bit(enc_bit), .est_out(est_out), .step_out(step_out)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      failures++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int fl(input bit [1:0] c);
    case (c)
      2'd0: return 1;
      2'd1: return 8;
      2'd2: return 32;
      default: return 128;
    endcase
  endfunction

  function automatic int next_step(input int s, input bit run, input bit [1:0] r, input bit [1:0] c);
    int v;
    if (run) v = s + (s >> ((r == 2'b01) ? 2 : 3)) + fl(c);
    else     v = s - (s >> ((r == 2'b01) ? 4 : 5));
    if (v < fl(c)) v = fl(c);
    if (v > 8192) v = 8192;
    return v;
  endfunction

  function automatic int next_est(input int e, input bit up, input int s);
    int v;
    v = e - (e >>> 8);
    v = up ? v + s : v - s;
    if (v > 32767) v = 32767;
    if (v < -32768) v = -32768;
    return v;
  endfunction

  task automatic wait_valid();
    do @(negedge clk); while (!enc_valid);
  endtask

  // one encoder update with the given sample, checked against the model
  task automatic do_update(input logic signed [15:0] s);
    bit b, run;
    int per;
    sample_in = s;
    wait_valid();
    per = cyc - last_cyc;
    if (period_ok)  // R2
      chk(per == 16 * (int'(div_load) + 1), "R2 period", per, 16 * (int'(div_load) + 1));
    last_cyc = cyc;
    period_ok = 1;
    b = (int'(s) >= m_est);
    run = (m_hist == {b, b}) ;
    m_step = next_step(m_step, run, rate_code, floor_code);
    m_est = next_est(m_est, b, m_step);
    m_hist = {m_hist[0], b};
    chk(enc_bit == b, "R4 bit", int'(enc_bit), int'(b));
    chk(int'(step_out) == m_step, run ? "R5 grow" : "R6 decay", int'(step_out), m_step);
    chk(int'(step_out) >= fl(floor_code), "R7 floor", int'(step_out), fl(floor_code));
    chk(int'(est_out) == m_est, "R8 est", int'(est_out), m_est);
    if (est_out == 16'sh7fff) seen_pos = 1;
    if (est_out == -16'sh8000) seen_neg = 1;
    @(negedge clk);
    chk(!enc_valid, "R4 pulse width", int'(enc_valid), 0);
  endtask

  initial begin
    int cnt;
    void'($urandom(32'd1234));
    rst = 1; div_load = 6'd3; rate_code = 2'b11; floor_code = 2'b00; sample_in = '0;
    repeat (5) @(negedge clk);
    // R1
    chk(enc_valid == 0 && est_out == 0 && step_out == 0 && enc_bit == 0, "R1 reset", int'(est_out), 0);
    rst = 0;
    @(negedge clk);
    chk(enc_valid == 0 && est_out == 0 && step_out == 0, "R1 after release", int'(step_out), 0);
    last_cyc = cyc;

    // random small-signal phase at 64 kHz, no floor
    for (int i = 0; i < 60; i++) do_update(16'($signed($urandom_range(0, 4000)) - 2000));
    // sine-like ramp with floor 01
    floor_code = 2'b01;
    for (int i = 0; i < 60; i++) do_update(16'((i % 20 < 10) ? (i % 10) * 1500 : (10 - i % 10) * 1500 - 7000));
    // positive full scale drive at 32 kHz, floor 10 (R9)
    rate_code = 2'b01; floor_code = 2'b10;
    period_ok = 0;
    for (int i = 0; i < 60; i++) do_update(16'sh7fff);
    chk(est_out == 16'sh7fff, "R9 positive saturation", int'(est_out), 32767);
    // negative full scale drive at 50 kHz, floor 11
    rate_code = 2'b10; floor_code = 2'b11;
    period_ok = 0;
    for (int i = 0; i < 60; i++) do_update(-16'sh8000);
    chk(seen_pos && seen_neg, "R9 both limits reached", int'(seen_neg), 1);
    // random mixed configs, changes only between updates
    div_load = 6'd5;
    period_ok = 0;
    for (int i = 0; i < 100; i++) begin
      if (i % 10 == 0) begin
        rate_code = 2'($urandom_range(1, 3));
        floor_code = 2'($urandom_range(0, 3));
      end
      do_update(16'($urandom));
    end
    // halted rate code (R3)
    rate_code = 2'b00;
    cnt = 0;
    repeat (3000) begin
      @(negedge clk);
      if (enc_valid) cnt++;
    end
    chk(cnt == 0, "R3 halted", cnt, 0);
    chk(int'(est_out) == m_est, "R3 estimate held", int'(est_out), m_est);
    rate_code = 2'b11;
    period_ok = 0;
    for (int i = 0; i < 20; i++) do_update(16'($urandom));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule